// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block lets several processors pass 32-bit words to each other through a set of small hardware queues. A processor posts a word by writing a queue's message register and takes the oldest word by reading that same register. Each queue also shows its current fill level and whether it has room for more.

Every user, meaning any processor that wants to be told about traffic, owns a private bank of three registers: an event status word, an enable-set port and an enable-clear port. Two event bits belong to each queue. One is raised when a word arrives and the other when a full queue gives up a slot. Each user has its own interrupt line, which follows the events that user has enabled. Software can therefore sleep until a message arrives or until a blocked sender can continue.

The queue count, user count and queue depth are parameters. The defaults are 4 queues, 2 users and a depth of 4. Register access is a single-cycle select/write strobe with a registered read port.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty. All fill-level, full, status and enable registers read 0, and every interrupt line is low.
- R2: Offset 0x000 reads the constant `REV` parameter. Writes to it have no effect.
- R3: A write to offset 0x040+4*m appends the write data to queue m. A read of that offset returns and removes the oldest word, so words leave in arrival order.
- R4: Offset 0x0C0+4*m reads the number of unread words in queue m, in bits [CW-1:0].
- R5: Offset 0x080+4*m reads 1 when queue m holds DEPTH words, and 0 otherwise.
- R6: A write to a full queue is dropped. The queue's level and its stored words do not change.
- R7: A read of an empty queue returns 0 and leaves the queue empty.
- R8: For user u, the status word is at 0x104+0x10*u. Bit 2*m is set in every user's status on each write that queue m accepts.
- R9: Status bit 2*m+1 is set in every user's status when a read takes a word from queue m while that queue is full.
- R10: Writing a 1 to a status bit clears it. The exception is bit 2*m: it stays set if queue m still holds words when the clear is written.
- R11: Writing 1s to 0x108+0x10*u adds those bits to user u's enable mask. Writing 1s to 0x10C+0x10*u removes them. Both offsets read the current mask.
- R12: `irq[u]` is high exactly when user u's status and enable share a set bit. It reflects a register write on the cycle after the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered at the access edge |
| irq | output | NUM_U | One interrupt line per user |

## Verification
Every effect of an access lands at the clock edge that samples the strobe. Queue levels, status bits and enable masks change there, and read data is loaded into `bus_rdata` at that same edge. The interrupt lines are formed from registers with no further delay, so they move in the same cycle as the status or enable change. The bench drives each access on a falling edge and reads `bus_rdata` and `irq` on the next falling edge, half a cycle after the edge that carried the access. Every result is checked there and never at a clock edge.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_REV,
        ACC_MSG,
        ACC_FULL,
        ACC_CNT,
        ACC_STAT,
        ACC_ENSET,
        ACC_ENCLR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } acc_t;

    // Queue registers live below 0x100 (index in a[5:2]); user banks above (index in a[7:4]).
    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a, input int nq, input int nu);
        acc_t r;
        r.kind = ACC_NONE;
        r.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (a[11:8] == 4'h0) begin
                if (a[7:0] == 8'h00) begin
                    r.kind = ACC_REV;
                end else if (a[7:6] != 2'b00 && int'(a[5:2]) < nq) begin
                    r.idx = {4'b0000, a[5:2]};
                    case (a[7:6])
                        2'b01:   r.kind = ACC_MSG;
                        2'b10:   r.kind = ACC_FULL;
                        default: r.kind = ACC_CNT;
                    endcase
                end
            end else if (a[11:8] == 4'h1 && int'(a[7:4]) < nu) begin
                r.idx = {4'b0000, a[7:4]};
                case (a[3:2])
                    2'b01:   r.kind = ACC_STAT;
                    2'b10:   r.kind = ACC_ENSET;
                    2'b11:   r.kind = ACC_ENCLR;
                    default: r.kind = ACC_NONE;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (do_push) begin
            wr_ptr <= bump(wr_ptr);
            count  <= count + 1'b1;
        end else if (do_pop) begin
            rd_ptr <= bump(rd_ptr);
            count  <= count - 1'b1;
        end
    end

endmodule

// File: rtl/ipc_mbx_user.sv
module ipc_mbx_user #(
    parameter int NQ = 4,
    localparam int EVW = 2 * NQ
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [EVW-1:0] evt,
    input  logic [EVW-1:0] w1c,
    input  logic [EVW-1:0] en_set,
    input  logic [EVW-1:0] en_clr,
    input  logic [NQ-1:0]  nonempty,
    output logic [EVW-1:0] stat,
    output logic [EVW-1:0] en,
    output logic           irq
);

    logic [EVW-1:0] keep;

    // Arrival events of a queue that still holds data refuse to be cleared.
    always_comb begin
        for (int m = 0; m < NQ; m++) begin
            keep[2*m]     = nonempty[m];
            keep[2*m + 1] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~(w1c & ~keep)) | evt;
            en   <= (en | en_set) & ~en_clr;
        end
    end

    assign irq = |(stat & en);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int          NUM_Q = 4,
    parameter int          NUM_U = 2,
    parameter int          DEPTH = 4,
    parameter int          DW    = 32,
    parameter logic [31:0] REV   = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_U-1:0]  irq
);

    localparam int CW  = $clog2(DEPTH + 1);
    localparam int EVW = 2 * NUM_Q;

    acc_t acc;
    logic wr_acc, rd_acc;

    assign acc    = decode_addr(bus_addr, NUM_Q, NUM_U);
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    logic [NUM_Q-1:0]    q_push, q_pop, q_full, q_nonempty;
    logic [DW-1:0]       q_head  [NUM_Q];
    logic [CW-1:0]       q_count [NUM_Q];
    logic [NUM_Q*CW-1:0] cnt_flat;
    logic [EVW-1:0]      evt;

    for (genvar m = 0; m < NUM_Q; m++) begin : g_q
        assign q_push[m] = wr_acc && acc.kind == ACC_MSG && acc.idx == IDX_W'(m);
        assign q_pop[m]  = rd_acc && acc.kind == ACC_MSG && acc.idx == IDX_W'(m);

        ipc_mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[m]),
            .pop   (q_pop[m]),
            .wdata (bus_wdata),
            .head  (q_head[m]),
            .count (q_count[m]),
            .full  (q_full[m])
        );

        assign q_nonempty[m]         = (q_count[m] != '0);
        assign cnt_flat[m*CW +: CW]  = q_count[m];
        assign evt[2*m]              = q_push[m] && !q_full[m];
        assign evt[2*m + 1]          = q_pop[m] && q_full[m];
    end

    logic [EVW-1:0]       u_stat [NUM_U];
    logic [EVW-1:0]       u_en   [NUM_U];
    logic [NUM_U*EVW-1:0] stat_flat, en_flat, en_set_flat;

    for (genvar u = 0; u < NUM_U; u++) begin : g_u
        logic hit;
        logic [EVW-1:0] w1c, set_m, clr_m;

        assign hit   = wr_acc && acc.idx == IDX_W'(u);
        assign w1c   = (hit && acc.kind == ACC_STAT)  ? bus_wdata[EVW-1:0] : '0;
        assign set_m = (hit && acc.kind == ACC_ENSET) ? bus_wdata[EVW-1:0] : '0;
        assign clr_m = (hit && acc.kind == ACC_ENCLR) ? bus_wdata[EVW-1:0] : '0;

        ipc_mbx_user #(.NQ(NUM_Q)) u_user (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .w1c      (w1c),
            .en_set   (set_m),
            .en_clr   (clr_m),
            .nonempty (q_nonempty),
            .stat     (u_stat[u]),
            .en       (u_en[u]),
            .irq      (irq[u])
        );

        assign stat_flat[u*EVW +: EVW]   = u_stat[u];
        assign en_flat[u*EVW +: EVW]     = u_en[u];
        assign en_set_flat[u*EVW +: EVW] = set_m;
    end

    logic [DW-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (acc.kind)
            ACC_REV: rd_val = DW'(REV);
            ACC_MSG, ACC_FULL, ACC_CNT: begin
                for (int m = 0; m < NUM_Q; m++) begin
                    if (acc.idx == IDX_W'(m)) begin
                        if (acc.kind == ACC_MSG)
                            rd_val = q_nonempty[m] ? q_head[m] : '0;
                        else if (acc.kind == ACC_FULL)
                            rd_val = DW'(q_full[m]);
                        else
                            rd_val = DW'(q_count[m]);
                    end
                end
            end
            ACC_STAT, ACC_ENSET, ACC_ENCLR: begin
                for (int u = 0; u < NUM_U; u++) begin
                    if (acc.idx == IDX_W'(u))
                        rd_val = (acc.kind == ACC_STAT) ? DW'(u_stat[u]) : DW'(u_en[u]);
                end
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int NUM_Q = 4,
    parameter int NUM_U = 2,
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int EVW   = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_U-1:0]     irq,
    input logic [NUM_Q-1:0]     q_push,
    input logic [NUM_Q-1:0]     q_pop,
    input logic [NUM_Q*CW-1:0]  cnt_flat,
    input logic [NUM_U*EVW-1:0] stat_flat,
    input logic [NUM_U*EVW-1:0] en_flat,
    input logic [NUM_U*EVW-1:0] en_set_flat
);

    // R1
    reset_irq_low_chk: assert property (@(posedge clk) rst |=> (irq == '0));

    for (genvar m = 0; m < NUM_Q; m++) begin : g_qa
        // R4
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_flat[m*CW +: CW] <= CW'(DEPTH));
        // R6
        full_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_flat[m*CW +: CW] == CW'(DEPTH) && q_push[m]) |=> (cnt_flat[m*CW +: CW] == CW'(DEPTH)));
        // R7
        empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_flat[m*CW +: CW] == '0 && q_pop[m] && !q_push[m]) |=> (cnt_flat[m*CW +: CW] == '0));
        for (genvar u = 0; u < NUM_U; u++) begin : g_ua
            // R8
            newmsg_set_chk: assert property (@(posedge clk) disable iff (rst)
                (q_push[m] && cnt_flat[m*CW +: CW] != CW'(DEPTH)) |=> stat_flat[u*EVW + 2*m]);
        end
    end

    for (genvar u = 0; u < NUM_U; u++) begin : g_ea
        // R11
        enset_chk: assert property (@(posedge clk) disable iff (rst)
            (en_set_flat[u*EVW +: EVW] != '0) |=>
            ((en_flat[u*EVW +: EVW] & $past(en_set_flat[u*EVW +: EVW])) == $past(en_set_flat[u*EVW +: EVW])));
    end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .NUM_Q (NUM_Q),
    .NUM_U (NUM_U),
    .DEPTH (DEPTH),
    .CW    (CW),
    .EVW   (EVW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .q_push      (q_push),
    .q_pop       (q_pop),
    .cnt_flat    (cnt_flat),
    .stat_flat   (stat_flat),
    .en_flat     (en_flat),
    .en_set_flat (en_set_flat)
);

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;

    localparam logic [31:0] REV_V = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ipc_mailbox #(.NUM_Q(4), .NUM_U(2), .DEPTH(4), .DW(32), .REV(REV_V)) u_ipc_mailbox (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [11:0] a_msg(input int m);  return 12'(12'h040 + 4*m);  endfunction
    function automatic logic [11:0] a_full(input int m); return 12'(12'h080 + 4*m);  endfunction
    function automatic logic [11:0] a_cnt(input int m);  return 12'(12'h0C0 + 4*m);  endfunction
    function automatic logic [11:0] a_stat(input int u); return 12'(12'h104 + 16*u); endfunction
    function automatic logic [11:0] a_set(input int u);  return 12'(12'h108 + 16*u); endfunction
    function automatic logic [11:0] a_clr(input int u);  return 12'(12'h10C + 16*u); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 4; m++) begin
            expect_read("R1 count", a_cnt(m), 0);
            expect_read("R1 full", a_full(m), 0);
        end
        for (int u = 0; u < 2; u++) begin
            expect_read("R1 status", a_stat(u), 0);
            expect_read("R1 enable", a_set(u), 0);
        end
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_rev();
        expect_read("R2 revision", 12'h000, REV_V);
        bus_write(12'h000, 32'hFFFF_FFFF);
        expect_read("R2 revision after write", 12'h000, REV_V);
    endtask

    task automatic t_fifo();
        bus_write(a_msg(1), 32'hA1A1_0001);
        bus_write(a_msg(1), 32'hB2B2_0002);
        expect_read("R4 count two", a_cnt(1), 2);
        expect_read("R8 user0 newmsg", a_stat(0), 32'h04);
        expect_read("R8 user1 newmsg", a_stat(1), 32'h04);
        expect_read("R3 first out", a_msg(1), 32'hA1A1_0001);
        expect_read("R3 second out", a_msg(1), 32'hB2B2_0002);
        expect_read("R4 count zero", a_cnt(1), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) bus_write(a_msg(2), 32'hC000_0000 + 32'(i));
        expect_read("R5 full set", a_full(2), 1);
        expect_read("R4 count depth", a_cnt(2), 4);
        bus_write(a_msg(2), 32'hDEAD_BEEF);
        expect_read("R6 count after drop", a_cnt(2), 4);
        expect_read("R9 notfull clear before", a_stat(0), 32'h14);
        expect_read("R6 oldest kept", a_msg(2), 32'hC000_0000);
        expect_read("R9 notfull set", a_stat(0), 32'h34);
        expect_read("R5 full cleared", a_full(2), 0);
        for (int i = 1; i < 4; i++) expect_read("R6 contents unchanged", a_msg(2), 32'hC000_0000 + 32'(i));
    endtask

    task automatic t_empty();
        expect_read("R7 empty read", a_msg(3), 0);
        expect_read("R7 count stays", a_cnt(3), 0);
    endtask

    task automatic t_w1c();
        bus_write(a_stat(0), 32'hFF);
        expect_read("R10 cleared", a_stat(0), 0);
        bus_write(a_msg(0), 32'h1234_5678);
        bus_write(a_stat(0), 32'h01);
        expect_read("R10 held while nonempty", a_stat(0), 32'h01);
        expect_read("R3 single word", a_msg(0), 32'h1234_5678);
        bus_write(a_stat(0), 32'h01);
        expect_read("R10 cleared when empty", a_stat(0), 0);
        expect_read("R8 user1 independent", a_stat(1), 32'h35);
    endtask

    task automatic t_en();
        bus_write(a_set(1), 32'h05);
        expect_read("R11 set", a_set(1), 32'h05);
        bus_write(a_set(1), 32'h02);
        expect_read("R11 set or", a_set(1), 32'h07);
        bus_write(a_clr(1), 32'h04);
        expect_read("R11 clear", a_clr(1), 32'h03);
        expect_read("R11 user0 untouched", a_set(0), 0);
    endtask

    task automatic t_irq();
        bus_write(a_stat(1), 32'hFF);
        check("R12 irq quiet", 32'(irq), 0);
        bus_write(a_msg(0), 32'h0000_00AA);
        check("R12 irq raised", 32'(irq), 32'b10);
        bus_write(a_clr(1), 32'h01);
        check("R12 irq masked", 32'(irq), 0);
        bus_write(a_set(1), 32'h01);
        check("R12 irq unmasked", 32'(irq), 32'b10);
        expect_read("R3 irq word", a_msg(0), 32'h0000_00AA);
        bus_write(a_stat(1), 32'h01);
        check("R12 irq after ack", 32'(irq), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rev();
        t_fifo();
        t_full();
        t_empty();
        t_w1c();
        t_en();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule